// File: doc/BRIEF.md
# Translation Table Region Selector

This block decides which of two translation-table base regions covers a 64-bit input address. The lower region owns addresses whose upper bits are all zero. The upper region owns addresses whose upper bits are all one. Each region has its own configuration: a size field that gives how many upper address bits must match, a disable flag, a top-byte-ignore enable and a granule code. Address bit 55 picks which of the two top-byte-ignore enables applies. When that enable is set, the top 8 bits of the address are left out of the check.

A region whose size field is zero takes every address that the other region does not claim. An address that falls between two configured regions is a translation fault. So is an address that lands in a disabled region. Otherwise the block reports the region index together with that region's size field and granule code, so that a table walker can start from them.

The decision logic is combinational. A parameter adds one output register stage, which gives one cycle of latency.

Top module: `xlat_region_sel`

## Requirements
- R1: The top-byte-ignore enable that applies comes from the upper region's configuration when address bit 55 is 1, and from the lower region's configuration when bit 55 is 0.
- R2: For a region with size field S, the checked bits are address bits 64-S up to 63. When top-byte-ignore applies, bits 56..63 are removed from that set. An empty checked set counts as a match for both the all-zero test and the all-ones test.
- R3: If the lower size field is nonzero and every checked bit is 0, the lower region (index 0) is chosen. This test has priority over every other rule.
- R4: If R3 does not apply, the upper size field is nonzero and every checked bit for the upper size is 1, the upper region (index 1) is chosen.
- R5: If neither R3 nor R4 applies and the lower size field is zero, the lower region (index 0) is chosen.
- R6: If R3, R4 and R5 do not apply and the upper size field is zero, the upper region (index 1) is chosen.
- R7: If both size fields are nonzero and the address matches neither region, fault_o is 1.
- R8: If the chosen region's disable flag is 1, fault_o is 1.
- R9: When fault_o is 1, reg_sel_o, sel_tsz_o and sel_gran_o are all zero. When fault_o is 0, sel_tsz_o and sel_gran_o equal the size field and granule code of the region named by reg_sel_o.
- R10: With REG_OUT=1 the outputs show the result for the inputs sampled at the previous rising clock edge. While rst_n is low all outputs are zero. With REG_OUT=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| addr_i | input | 64 | Input address |
| lo_tsz_i | input | 6 | Lower region size field |
| lo_gran_i | input | 2 | Lower region granule code |
| lo_off_i | input | 1 | Lower region disable flag |
| lo_tag_ign_i | input | 1 | Lower region top-byte-ignore enable |
| hi_tsz_i | input | 6 | Upper region size field |
| hi_gran_i | input | 2 | Upper region granule code |
| hi_off_i | input | 1 | Upper region disable flag |
| hi_tag_ign_i | input | 1 | Upper region top-byte-ignore enable |
| reg_sel_o | output | 1 | Chosen region: 0 lower, 1 upper |
| fault_o | output | 1 | Translation fault |
| sel_tsz_o | output | 6 | Size field of the chosen region |
| sel_gran_o | output | 2 | Granule code of the chosen region |

## Verification
The checker keeps its own delayed copy of the configuration inputs so that it can compare the outputs with them. This relies on the configuration being valid at every rising edge once reset is released, and on no X values being driven on it. The bench changes inputs only at falling edges, drives every input on each step and holds it until the next step, so the checker's copy always matches the outputs it is compared with. Random stimulus uses size fields and sign-filled upper address bits chosen so that hits, gaps and empty-field cases all occur often. Directed cases cover the tag and priority corners.

// File: rtl/xlat_region_pkg.sv
package xlat_region_pkg;
   // Region index encoding
   localparam logic REGION_LO = 1'b0;
   localparam logic REGION_HI = 1'b1;

   // Outcome of the priority decision
   typedef enum logic [2:0] {
      PICK_LO_HIT   = 3'd0,
      PICK_HI_HIT   = 3'd1,
      PICK_LO_ALL   = 3'd2,
      PICK_HI_ALL   = 3'd3,
      PICK_GAP      = 3'd4
   } pick_kind_e;
endpackage

// File: rtl/xlat_tag_mask.sv
// Builds the mask of checked upper address bits for one size field.
module xlat_tag_mask #(
   parameter int ADDR_W = 64,
   parameter int TAG_W  = 8,
   parameter int TSZ_W  = 6
) (
   input  logic [TSZ_W-1:0]  tsz_i,
   input  logic              tag_ign_i,
   output logic [ADDR_W-1:0] mask_o
);
   localparam int SUM_W = TSZ_W + 2;

   for (genvar p = 0; p < ADDR_W; p++) begin : g_bit
      localparam bit IN_TAG = (p >= ADDR_W - TAG_W);
      logic in_range;
      // bit p is covered when p + tsz >= ADDR_W
      assign in_range = ({2'b00, tsz_i} + SUM_W'(p)) >= SUM_W'(ADDR_W);
      if (IN_TAG) begin : g_tag
         assign mask_o[p] = in_range & ~tag_ign_i;
      end else begin : g_plain
         assign mask_o[p] = in_range;
      end
   end
endmodule

// File: rtl/xlat_region_match.sv
// Tests the checked bits of an address against all-zero and all-one.
module xlat_region_match #(
   parameter int ADDR_W = 64,
   parameter int TAG_W  = 8,
   parameter int TSZ_W  = 6,
   parameter bit WANT_ONES = 1'b0
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [TSZ_W-1:0]  tsz_i,
   input  logic              tag_ign_i,
   output logic              hit_o,
   output logic              empty_o
);
   logic [ADDR_W-1:0] mask;

   xlat_tag_mask #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .TSZ_W(TSZ_W)) u_mask (
      .tsz_i     (tsz_i),
      .tag_ign_i (tag_ign_i),
      .mask_o    (mask)
   );

   assign empty_o = (tsz_i == '0);

   if (WANT_ONES) begin : g_ones
      assign hit_o = ~empty_o & (&(addr_i | ~mask));
   end else begin : g_zeros
      assign hit_o = ~empty_o & ~(|(addr_i & mask));
   end
endmodule

// File: rtl/xlat_region_pick.sv
// Priority decision among the two regions, then disable check.
module xlat_region_pick
   import xlat_region_pkg::*;
(
   input  logic lo_hit_i,
   input  logic hi_hit_i,
   input  logic lo_empty_i,
   input  logic hi_empty_i,
   input  logic lo_off_i,
   input  logic hi_off_i,
   output logic sel_o,
   output logic fault_o
);
   pick_kind_e kind;

   always_comb begin
      if (lo_hit_i)        kind = PICK_LO_HIT;
      else if (hi_hit_i)   kind = PICK_HI_HIT;
      else if (lo_empty_i) kind = PICK_LO_ALL;
      else if (hi_empty_i) kind = PICK_HI_ALL;
      else                 kind = PICK_GAP;
   end

   always_comb begin
      sel_o   = REGION_LO;
      fault_o = 1'b0;
      unique case (kind)
         PICK_LO_HIT, PICK_LO_ALL: begin
            sel_o   = REGION_LO;
            fault_o = lo_off_i;
         end
         PICK_HI_HIT, PICK_HI_ALL: begin
            sel_o   = REGION_HI;
            fault_o = hi_off_i;
         end
         default: begin
            sel_o   = REGION_LO;
            fault_o = 1'b1;
         end
      endcase
      if (fault_o) sel_o = REGION_LO;
   end
endmodule

// File: rtl/xlat_region_sel.sv
module xlat_region_sel #(
   parameter int ADDR_W  = 64,
   parameter int TAG_W   = 8,
   parameter int GRAN_W  = 2,
   parameter bit REG_OUT = 1'b1,
   localparam int TSZ_W   = $clog2(ADDR_W),
   localparam int SEL_BIT = ADDR_W - TAG_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [TSZ_W-1:0]  lo_tsz_i,
   input  logic [GRAN_W-1:0] lo_gran_i,
   input  logic              lo_off_i,
   input  logic              lo_tag_ign_i,
   input  logic [TSZ_W-1:0]  hi_tsz_i,
   input  logic [GRAN_W-1:0] hi_gran_i,
   input  logic              hi_off_i,
   input  logic              hi_tag_ign_i,
   output logic              reg_sel_o,
   output logic              fault_o,
   output logic [TSZ_W-1:0]  sel_tsz_o,
   output logic [GRAN_W-1:0] sel_gran_o
);
   initial begin
      if (ADDR_W < 16 || (ADDR_W & (ADDR_W - 1)) != 0)
         $fatal(1, "ADDR_W must be a power of two of at least 16");
      if (TAG_W < 1 || TAG_W >= ADDR_W - 1)
         $fatal(1, "TAG_W out of range");
      if (GRAN_W < 1)
         $fatal(1, "GRAN_W must be positive");
   end

   logic tag_ign;
   logic lo_hit, hi_hit, lo_empty, hi_empty;
   logic sel_c, fault_c;
   logic [TSZ_W-1:0]  tsz_c;
   logic [GRAN_W-1:0] gran_c;

   // R1: which tag enable applies
   assign tag_ign = addr_i[SEL_BIT] ? hi_tag_ign_i : lo_tag_ign_i;

   xlat_region_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .TSZ_W(TSZ_W),
                       .WANT_ONES(1'b0)) u_lo (
      .addr_i(addr_i), .tsz_i(lo_tsz_i), .tag_ign_i(tag_ign),
      .hit_o(lo_hit), .empty_o(lo_empty)
   );

   xlat_region_match #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .TSZ_W(TSZ_W),
                       .WANT_ONES(1'b1)) u_hi (
      .addr_i(addr_i), .tsz_i(hi_tsz_i), .tag_ign_i(tag_ign),
      .hit_o(hi_hit), .empty_o(hi_empty)
   );

   xlat_region_pick u_pick (
      .lo_hit_i(lo_hit), .hi_hit_i(hi_hit),
      .lo_empty_i(lo_empty), .hi_empty_i(hi_empty),
      .lo_off_i(lo_off_i), .hi_off_i(hi_off_i),
      .sel_o(sel_c), .fault_o(fault_c)
   );

   always_comb begin
      tsz_c  = '0;
      gran_c = '0;
      if (!fault_c) begin
         tsz_c  = sel_c ? hi_tsz_i  : lo_tsz_i;
         gran_c = sel_c ? hi_gran_i : lo_gran_i;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            reg_sel_o  <= 1'b0;
            fault_o    <= 1'b0;
            sel_tsz_o  <= '0;
            sel_gran_o <= '0;
         end else begin
            reg_sel_o  <= sel_c;
            fault_o    <= fault_c;
            sel_tsz_o  <= tsz_c;
            sel_gran_o <= gran_c;
         end
      end
   end else begin : g_comb
      assign reg_sel_o  = sel_c;
      assign fault_o    = fault_c;
      assign sel_tsz_o  = tsz_c;
      assign sel_gran_o = gran_c;
   end
endmodule

// File: rtl/xlat_region_sel_chk.sv
module xlat_region_sel_chk #(
   parameter int ADDR_W  = 64,
   parameter int GRAN_W  = 2,
   parameter bit REG_OUT = 1'b1,
   localparam int TSZ_W  = $clog2(ADDR_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TSZ_W-1:0]  lo_tsz_i,
   input logic [GRAN_W-1:0] lo_gran_i,
   input logic              lo_off_i,
   input logic [TSZ_W-1:0]  hi_tsz_i,
   input logic [GRAN_W-1:0] hi_gran_i,
   input logic              hi_off_i,
   input logic              reg_sel_o,
   input logic              fault_o,
   input logic [TSZ_W-1:0]  sel_tsz_o,
   input logic [GRAN_W-1:0] sel_gran_o
);
   logic [TSZ_W-1:0]  lo_tsz_d, hi_tsz_d;
   logic [GRAN_W-1:0] lo_gran_d, hi_gran_d;
   logic              lo_off_d, hi_off_d;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_tsz_d <= '0; hi_tsz_d <= '0; lo_gran_d <= '0; hi_gran_d <= '0;
            lo_off_d <= 1'b0; hi_off_d <= 1'b0;
         end else begin
            lo_tsz_d <= lo_tsz_i; hi_tsz_d <= hi_tsz_i;
            lo_gran_d <= lo_gran_i; hi_gran_d <= hi_gran_i;
            lo_off_d <= lo_off_i; hi_off_d <= hi_off_i;
         end
      end
   end else begin : g_now
      assign lo_tsz_d = lo_tsz_i;   assign hi_tsz_d = hi_tsz_i;
      assign lo_gran_d = lo_gran_i; assign hi_gran_d = hi_gran_i;
      assign lo_off_d = lo_off_i;   assign hi_off_d = hi_off_i;
   end

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (!reg_sel_o && sel_tsz_o == '0 && sel_gran_o == '0));

   // R8
   lo_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_o && !reg_sel_o) |-> !lo_off_d);

   // R8
   hi_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_o && reg_sel_o) |-> !hi_off_d);

   // R9
   cfg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_o |-> (sel_tsz_o == (reg_sel_o ? hi_tsz_d : lo_tsz_d) &&
                    sel_gran_o == (reg_sel_o ? hi_gran_d : lo_gran_d)));

   // R5
   both_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_tsz_d == '0 && hi_tsz_d == '0 && !lo_off_d) |-> (!fault_o && !reg_sel_o));

   // R7
   no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_tsz_d == '0 && !lo_off_d && !hi_off_d) |-> !fault_o);
endmodule

bind xlat_region_sel xlat_region_sel_chk #(
   .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lo_tsz_i(lo_tsz_i), .lo_gran_i(lo_gran_i), .lo_off_i(lo_off_i),
   .hi_tsz_i(hi_tsz_i), .hi_gran_i(hi_gran_i), .hi_off_i(hi_off_i),
   .reg_sel_o(reg_sel_o), .fault_o(fault_o),
   .sel_tsz_o(sel_tsz_o), .sel_gran_o(sel_gran_o)
);

// File: tb/xlat_region_sel_tb.sv
module xlat_region_sel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] addr = '0;
   logic [5:0]  lo_tsz = '0, hi_tsz = '0;
   logic [1:0]  lo_gran = '0, hi_gran = '0;
   logic        lo_off = 1'b0, hi_off = 1'b0, lo_tag = 1'b0, hi_tag = 1'b0;
   logic        sel, fault;
   logic [5:0]  tsz_o;
   logic [1:0]  gran_o;
   int          n_chk = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   xlat_region_sel u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .lo_tsz_i(lo_tsz), .lo_gran_i(lo_gran), .lo_off_i(lo_off), .lo_tag_ign_i(lo_tag),
      .hi_tsz_i(hi_tsz), .hi_gran_i(hi_gran), .hi_off_i(hi_off), .hi_tag_ign_i(hi_tag),
      .reg_sel_o(sel), .fault_o(fault), .sel_tsz_o(tsz_o), .sel_gran_o(gran_o)
   );

   // all checked bits equal v (empty set matches)
   function automatic bit field_is(input logic [63:0] a, input int s, input bit ign, input bit v);
      int top = ign ? 56 : 64;
      for (int b = 64 - s; b < top; b++) if (a[b] != v) return 1'b0;
      return 1'b1;
   endfunction

   // returns {fault, sel, tsz, gran}
   function automatic logic [9:0] model();
      bit ign = addr[55] ? hi_tag : lo_tag;
      bit s, f;
      if (lo_tsz != 0 && field_is(addr, int'(lo_tsz), ign, 1'b0))      begin s = 0; f = lo_off; end
      else if (hi_tsz != 0 && field_is(addr, int'(hi_tsz), ign, 1'b1)) begin s = 1; f = hi_off; end
      else if (lo_tsz == 0) begin s = 0; f = lo_off; end
      else if (hi_tsz == 0) begin s = 1; f = hi_off; end
      else begin s = 0; f = 1; end
      if (f) return {1'b1, 1'b0, 6'd0, 2'd0};
      return {1'b0, s, s ? hi_tsz : lo_tsz, s ? hi_gran : lo_gran};
   endfunction

   task automatic check(input string req, input logic [9:0] exp);
      n_chk++;
      if ({fault, sel, tsz_o, gran_o} !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h got=%b exp=%b", req, addr, {fault, sel, tsz_o, gran_o}, exp);
      end
   endtask

   // drive at a falling edge, compare one edge later (R10 latency)
   task automatic step(input string req, input logic [63:0] a,
                       input logic [5:0] lt, input logic [5:0] ht,
                       input bit lo_t, input bit hi_t, input bit lo_d, input bit hi_d);
      logic [9:0] exp;
      addr = a; lo_tsz = lt; hi_tsz = ht; lo_tag = lo_t; hi_tag = hi_t;
      lo_off = lo_d; hi_off = hi_d; lo_gran = 2'd1; hi_gran = 2'd2;
      exp = model();
      @(negedge clk);
      check(req, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R10 reset", 10'd0);
      rst_n = 1'b1;
      // R3: lower hit
      step("R3", 64'h0000_0000_1234_5000, 6'd16, 6'd16, 0, 0, 0, 0);
      check("R3 idx0", {1'b0, 1'b0, 6'd16, 2'd1});
      // R4: upper hit
      step("R4", 64'hFFFF_0000_0000_1000, 6'd16, 6'd16, 0, 0, 0, 0);
      check("R4 idx1", {1'b0, 1'b1, 6'd16, 2'd2});
      // R7: gap
      step("R7", 64'h00F0_0000_0000_0000, 6'd16, 6'd16, 0, 0, 0, 0);
      check("R7 gap", {1'b1, 1'b0, 6'd0, 2'd0});
      // R2 + R1: tag byte ignored through lower enable (bit55=0)
      step("R2", 64'hAB00_0000_0000_0040, 6'd16, 6'd16, 1, 0, 0, 0);
      check("R2 tag ign", {1'b0, 1'b0, 6'd16, 2'd1});
      // R1: bit55=0 so upper enable is not used -> gap
      step("R1", 64'hAB00_0000_0000_0040, 6'd16, 6'd16, 0, 1, 0, 0);
      check("R1 lo flag", {1'b1, 1'b0, 6'd0, 2'd0});
      // R1: bit55=1 uses upper enable, tag byte 0x12 ignored -> upper
      step("R1", 64'h12FF_0000_0000_0000, 6'd16, 6'd16, 0, 1, 0, 0);
      check("R1 hi flag", {1'b0, 1'b1, 6'd16, 2'd2});
      // R5: lower size zero takes the rest
      step("R5", 64'h00F0_0000_0000_0000, 6'd0, 6'd16, 0, 0, 0, 0);
      check("R5 lo all", {1'b0, 1'b0, 6'd0, 2'd1});
      // R6: upper size zero takes the rest
      step("R6", 64'h00F0_0000_0000_0000, 6'd16, 6'd0, 0, 0, 0, 0);
      check("R6 hi all", {1'b0, 1'b1, 6'd0, 2'd2});
      // R8: disabled region
      step("R8", 64'hFFFF_0000_0000_1000, 6'd16, 6'd16, 0, 0, 0, 1);
      check("R8 off", {1'b1, 1'b0, 6'd0, 2'd0});
      // R3 priority with empty checked field: both match, lower wins
      step("R3", 64'h5A5A_5A5A_5A5A_5A5A, 6'd8, 6'd8, 1, 1, 0, 0);
      check("R3 prio", {1'b0, 1'b0, 6'd8, 2'd1});
      // R9: off lower when upper size zero falls into lower? lower hit disabled
      step("R9", 64'h0, 6'd20, 6'd0, 0, 0, 1, 0);
      check("R9 zeroed", {1'b1, 1'b0, 6'd0, 2'd0});
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] a;
         logic [5:0]  lt, ht;
         int k = $urandom_range(0, 63);
         a = {$urandom, $urandom};
         case ($urandom_range(0, 2))
            0: a = a >> k;
            1: a = ~((~a) >> k);
            default: ;
         endcase
         lt = ($urandom_range(0, 5) == 0) ? 6'd0 : 6'($urandom_range(1, 63));
         ht = ($urandom_range(0, 5) == 0) ? 6'd0 : 6'($urandom_range(1, 63));
         step("R1-rand R2 R3 R4 R5 R6 R7 R8 R9", a, lt, ht, 1'($urandom), 1'($urandom),
              ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule